// File: doc/BRIEF.md
# Three-Phase Bridge Gate Guard

This block sits between a commutation controller and the gate drivers of three half-bridge legs. Each leg has two requests: an active-low request for its high-side switch and an active-high request for its low-side switch. The block turns these requests into six active-high gate enables. If a leg is asked to drive high and low at once, neither of its switches is turned on, and that leg floats.

Two protection paths can override the commutation requests. A falling active-low brake input first turns every switch off. The block then counts a programmable number of clock cycles and clamps the winding by turning on all low-side switches. If the brake input returns high before the count ends, the sequence is cancelled. A temperature code in degrees Celsius drives a trip flag with hysteresis. While the flag is set, every switch is off, and this takes precedence over the brake clamp. The off-only interval at the start of a brake gives the motor's back-EMF time to be used for head parking. The delay must therefore be set longer than the parking time. A typical setting is around 150 ms, expressed in clock cycles.

Top module: `bridge_guard`

## Requirements
- R1: While reset is applied, and in the first cycles after it, all six gate enables are 0.
- R2: A leg's high-side enable is 1 when its request is 0 and its low-side request is 0. Its low-side enable is 1 when its low request is 1 and its high request is 1. Outputs update on the clock edge that samples the inputs.
- R3: A leg whose high request is 0 while its low request is 1 has both enables 0. The other legs are decoded normally.
- R4: On the first edge that samples brake_n = 0, all enables go to 0. They stay at 0 for brake_dly sampled cycles.
- R5: After exactly brake_dly output cycles of the all-off state, with brake_n still 0, all low-side enables are 1 and all high-side enables are 0. The commutation inputs are ignored. With brake_dly = 0, the clamp starts at the first edge.
- R6: A sampled brake_n = 1 clears the delay count. A later brake starts the full delay again.
- R7: A sampled temp_c of 160 or more sets the thermal trip. While the trip is set, all enables are 0.
- R8: The trip clears only when a sampled temp_c is 120 or less. Codes from 121 to 159 keep the previous trip state.
- R9: Thermal trip overrides the brake clamp, and the brake overrides commutation.
- R10: A leg never has both of its enables at 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req_n | input | 3 | High-side requests per leg, active low |
| lo_req | input | 3 | Low-side requests per leg, active high |
| brake_n | input | 1 | Brake command, active low |
| temp_c | input | 8 | Unsigned temperature code in degrees Celsius |
| brake_dly | input | 24 | Release interval before the clamp, in clock cycles |
| up_en | output | 3 | High-side gate enables |
| lo_en | output | 3 | Low-side gate enables |

## Verification
Every result is due one edge after the inputs that cause it. This covers leg decoding, the trip flag and the immediate release. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. The clamp is due exactly brake_dly sampled cycles after the first all-off cycle. The bench's reference model steps its own delay count once per driven cycle. Each expectation is therefore compared in the cycle it falls due, and the hysteresis state is carried across cycles in the same way.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_RELEASE = 2'd1,
    MODE_CLAMP   = 2'd2,
    MODE_TRIP    = 2'd3
  } drive_mode_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/leg_decode.sv
module leg_decode
  import bridge_pkg::*;
(
  input  logic       up_req_n,
  input  logic       lo_req,
  output gate_pair_t pair
);
  logic want_hi;
  logic want_lo;
  logic clash;

  always_comb begin
    want_hi = ~up_req_n;
    want_lo = lo_req;
    clash   = want_hi & want_lo;
    pair.hi = want_hi & ~clash;
    pair.lo = want_lo & ~clash;
  end
endmodule

// File: rtl/thermal_trip.sv
module thermal_trip #(
  parameter int TEMP_W  = 8,
  parameter int T_TRIP  = 160,
  parameter int T_CLEAR = 120
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              hot_nxt,
  output logic              hot_q
);
  localparam logic [TEMP_W-1:0] TRIP_C  = TEMP_W'(T_TRIP);
  localparam logic [TEMP_W-1:0] CLEAR_C = TEMP_W'(T_CLEAR);

  logic over;
  logic under;

  always_comb begin
    over  = (temp_c >= TRIP_C);
    under = (temp_c <= CLEAR_C);
    if (over)       hot_nxt = 1'b1;
    else if (under) hot_nxt = 1'b0;
    else            hot_nxt = hot_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else         hot_q <= hot_nxt;
  end

  // R7
  trip_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (temp_c >= TRIP_C) |=> hot_q);

  // R8
  trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (temp_c <= CLEAR_C) |=> !hot_q);

  // R8
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((temp_c > CLEAR_C) && (temp_c < TRIP_C)) |=> (hot_q == $past(hot_q)));
endmodule

// File: rtl/brake_timer.sv
module brake_timer #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             brake_n,
  input  logic [DLY_W-1:0] brake_dly,
  output logic             clamp
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    clamp  = ~brake_n & (cnt_q >= brake_dly);
    cnt_en = brake_n | (cnt_q < brake_dly);
    cnt_d  = brake_n ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    brake_n |=> (cnt_q == '0));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clamp && $stable(brake_dly)) |=> $stable(cnt_q));
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bridge_pkg::*;
#(
  parameter int LEGS    = 3,
  parameter int TEMP_W  = 8,
  parameter int T_TRIP  = 160,
  parameter int T_CLEAR = 120,
  parameter int DLY_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEGS-1:0]   up_req_n,
  input  logic [LEGS-1:0]   lo_req,
  input  logic              brake_n,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [DLY_W-1:0]  brake_dly,
  output logic [LEGS-1:0]   up_en,
  output logic [LEGS-1:0]   lo_en
);
  logic        rst_s;
  logic        hot_nxt;
  logic        hot_q;
  logic        clamp;
  drive_mode_t mode;
  gate_pair_t  leg_pair [LEGS];
  logic [LEGS-1:0] up_d;
  logic [LEGS-1:0] lo_d;

  rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  thermal_trip #(
    .TEMP_W (TEMP_W),
    .T_TRIP (T_TRIP),
    .T_CLEAR(T_CLEAR)
  ) u_therm (
    .clk     (clk),
    .rst_ni  (rst_s),
    .temp_c  (temp_c),
    .hot_nxt (hot_nxt),
    .hot_q   (hot_q)
  );

  brake_timer #(
    .DLY_W (DLY_W)
  ) u_brk (
    .clk       (clk),
    .rst_ni    (rst_s),
    .brake_n   (brake_n),
    .brake_dly (brake_dly),
    .clamp     (clamp)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    leg_decode u_leg (
      .up_req_n (up_req_n[g]),
      .lo_req   (lo_req[g]),
      .pair     (leg_pair[g])
    );
  end

  always_comb begin
    if (hot_nxt)       mode = MODE_TRIP;
    else if (clamp)    mode = MODE_CLAMP;
    else if (!brake_n) mode = MODE_RELEASE;
    else               mode = MODE_RUN;
  end

  always_comb begin
    for (int i = 0; i < LEGS; i++) begin
      case (mode)
        MODE_RUN: begin
          up_d[i] = leg_pair[i].hi;
          lo_d[i] = leg_pair[i].lo;
        end
        MODE_CLAMP: begin
          up_d[i] = 1'b0;
          lo_d[i] = 1'b1;
        end
        default: begin
          up_d[i] = 1'b0;
          lo_d[i] = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      up_en <= '0;
      lo_en <= '0;
    end else begin
      up_en <= up_d;
      lo_en <= lo_d;
    end
  end

  // R10
  no_shoot_thru_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((up_en & lo_en) == '0));

  // R4
  brake_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !brake_n |=> (up_en == '0));

  // R5
  clamp_lo_on_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (clamp && !hot_nxt) |=> (lo_en == '1));

  // R9
  trip_all_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    hot_q |-> ((up_en == '0) && (lo_en == '0)));
endmodule

// File: tb/sim_bridge_guard.sv
module sim_bridge_guard;
  logic        clk;
  logic        rst_n;
  logic [2:0]  up_req_n;
  logic [2:0]  lo_req;
  logic        brake_n;
  logic [7:0]  temp_c;
  logic [23:0] brake_dly;
  logic [2:0]  up_en;
  logic [2:0]  lo_en;

  int total;
  int bad;
  int m_cnt;
  bit m_hot;

  bridge_guard u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req_n  (up_req_n),
    .lo_req    (lo_req),
    .brake_n   (brake_n),
    .temp_c    (temp_c),
    .brake_dly (brake_dly),
    .up_en     (up_en),
    .lo_en     (lo_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [5:0] ref_out(input logic [2:0] un, input logic [2:0] lr,
                                         input logic b, input bit hot, input bit clamp);
    logic [2:0] u;
    logic [2:0] l;
    if (hot) return 6'b0;
    if (!b) return clamp ? {3'b000, 3'b111} : 6'b0;
    for (int i = 0; i < 3; i++) begin
      u[i] = !un[i] && !lr[i];
      l[i] = lr[i] && un[i];
    end
    return {u, l};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got up=%b lo=%b expected up=%b lo=%b",
               tag, got[5:3], got[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic step(input logic [2:0] un, input logic [2:0] lr, input logic b,
                      input logic [7:0] t, input logic [23:0] d, input string tag);
    logic [5:0] exp;
    bit clamp;
    @(negedge clk);
    up_req_n = un; lo_req = lr; brake_n = b; temp_c = t; brake_dly = d;
    if (t >= 8'd160)      m_hot = 1'b1;
    else if (t <= 8'd120) m_hot = 1'b0;
    clamp = !b && (m_cnt >= int'(d));
    exp = ref_out(un, lr, b, m_hot, clamp);
    if (b)                    m_cnt = 0;
    else if (m_cnt < int'(d)) m_cnt++;
    @(posedge clk);
    #1;
    check(tag, {up_en, lo_en}, exp);
    total++;
    if ((up_en & lo_en) != 3'b000) begin
      bad++;
      $display("FAIL R10: got up=%b lo=%b expected no overlap", up_en, lo_en);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; m_cnt = 0; m_hot = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; up_req_n = 3'b111; lo_req = 3'b000; brake_n = 1'b1;
    temp_c = 8'd25; brake_dly = 24'd5;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", {up_en, lo_en}, 6'b0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(3'b111, 3'b000, 1'b1, 8'd25, 24'd5, "R1 after reset");

    // R2 decode
    step(3'b000, 3'b000, 1'b1, 8'd25, 24'd5, "R2 all high");
    step(3'b111, 3'b111, 1'b1, 8'd25, 24'd5, "R2 all low");
    step(3'b110, 3'b100, 1'b1, 8'd25, 24'd5, "R2 mixed");
    // R3 cross request
    step(3'b000, 3'b111, 1'b1, 8'd25, 24'd5, "R3 all clash");
    step(3'b100, 3'b001, 1'b1, 8'd25, 24'd5, "R3 one clash");

    // R4 / R5 brake with delay 5
    for (int i = 0; i < 5; i++) step(3'b101, 3'b010, 1'b0, 8'd25, 24'd5, "R4 release");
    for (int i = 0; i < 4; i++) step(3'($urandom), 3'($urandom), 1'b0, 8'd25, 24'd5, "R5 clamp");
    step(3'b110, 3'b001, 1'b1, 8'd25, 24'd5, "R6 resume");
    // R5 zero delay
    step(3'b000, 3'b000, 1'b0, 8'd25, 24'd0, "R5 zero delay");
    step(3'b111, 3'b111, 1'b1, 8'd25, 24'd0, "R6 resume");
    // R6 abort and restart
    for (int i = 0; i < 3; i++) step(3'b011, 3'b000, 1'b0, 8'd25, 24'd6, "R6 first low");
    step(3'b011, 3'b000, 1'b1, 8'd25, 24'd6, "R6 abort");
    for (int i = 0; i < 6; i++) step(3'b011, 3'b000, 1'b0, 8'd25, 24'd6, "R6 full delay again");
    step(3'b011, 3'b000, 1'b0, 8'd25, 24'd6, "R6 clamp after restart");

    // R7 / R8 thermal
    step(3'b000, 3'b000, 1'b1, 8'd159, 24'd6, "R7 below trip");
    step(3'b000, 3'b000, 1'b1, 8'd160, 24'd6, "R7 trip");
    step(3'b000, 3'b000, 1'b1, 8'd140, 24'd6, "R8 hold");
    step(3'b000, 3'b000, 1'b1, 8'd121, 24'd6, "R8 hold edge");
    step(3'b000, 3'b000, 1'b1, 8'd120, 24'd6, "R8 clear");
    step(3'b000, 3'b000, 1'b1, 8'd159, 24'd6, "R8 stay clear");
    // R9 trip over clamp
    for (int i = 0; i < 3; i++) step(3'b111, 3'b000, 1'b0, 8'd25, 24'd1, "R9 clamp before");
    step(3'b111, 3'b000, 1'b0, 8'd200, 24'd1, "R9 trip over clamp");
    step(3'b111, 3'b000, 1'b0, 8'd130, 24'd1, "R9 trip held");
    step(3'b111, 3'b000, 1'b0, 8'd100, 24'd1, "R9 clamp returns");
    step(3'b111, 3'b000, 1'b1, 8'd100, 24'd1, "R6 resume");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic b;
      logic [7:0] t;
      b = ($urandom % 8) != 0 ? ((i % 40) < 25) : 1'($urandom);
      t = 8'(100 + ($urandom % 80));
      step(3'($urandom), 3'($urandom), b, t, 24'($urandom % 8), "R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule